// File: doc/BRIEF.md
# Protected scratchpad write controller

This block sits behind a byte-serial command decoder and fills an 8-byte volatile staging buffer in front of a 144-byte paged nonvolatile array. The array has four 32-byte data pages at 0000h–007Fh and a register row at 0080h–008Fh. The first four bytes of the register row hold one protection code per data page. A write command first latches a 16-bit target address. It then streams data bytes into the buffer. Before a byte is stored, the protection code of the target page is applied to it.

The low three address bits give the starting lane in the buffer, and the lane pointer wraps after lane 7. For each byte the block looks up the array byte at the row base plus the current lane, and it looks up the protection code of the page. Depending on the code, the stored value is the incoming byte, the array byte, or the AND of the two. A status byte reports the lane of the last byte written, a partial-write flag and an already-copied flag. Two further outputs tell the later copy step whether the buffer is complete and whether the address lies beyond the array.

Data bytes enter on a valid/ready stream. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while a command is open, and it is low in any cycle that carries `addr_load` or `cmd_end`. A source that sees `in_ready` low keeps its byte and keeps `in_valid` high, and nothing is stored. The array read ports are combinational: the data must be returned in the same cycle the address is presented.

Top module: `spw_ctrl`

## Requirements
- R1: After reset, `es` is 20h, `in_ready` is 0, `target_addr` is 0, every buffer byte is 0, and both `copy_valid` and `target_invalid` are 0.
- R2: An `addr_load` pulse latches `addr_in` into `target_addr` and sets `es` bits 2:0 to `addr_in[2:0]`. It clears `es` bit 7 and sets `es` bit 5. It opens the command, so `in_ready` is 1 from the next cycle.
- R3: An accepted byte is stored unchanged into buffer lane `ptr` (bits `8*ptr+7:8*ptr` of `sp_data`) when the page is open. A page is open when its protection code is neither 55h nor AAh, or when the target address is 0080h or higher. `ptr` starts at `addr_in[2:0]` and advances by one per accepted byte, wrapping from 7 to 0.
- R4: If the protection code is 55h, the lane receives the array byte at address `{target_addr[15:3], ptr}`, and the incoming byte is discarded.
- R5: If the protection code is AAh, the lane receives the bitwise AND of the incoming byte and that array byte.
- R6: The first byte after an address load leaves `es` bits 2:0 unchanged. Each further accepted byte increments them modulo 8.
- R7: `es` bit 5 clears when a byte is accepted into lane 7. It stays set if the command ends before that. A cycle with `power_loss` high sets it, and this takes priority over a clear in the same cycle.
- R8: A `copied` pulse sets `es` bit 7. Any accepted byte or address load clears it, and an accepted byte wins over a `copied` pulse in the same cycle. `es` bits 6, 4 and 3 read 0.
- R9: `copy_valid` is 1 only when the start lane was 0, exactly 8 bytes were accepted since the address load, and `es` bit 5 is 0. `target_invalid` is 1 when `target_addr` is 0090h or higher.
- R10: Bytes offered while `in_ready` is low change no buffer lane and no status. This covers the cycles before any address load and after `cmd_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Latch `addr_in` and open a write command |
| addr_in | input | 16 | Target address |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Controller can take a byte this cycle |
| in_data | input | 8 | Incoming data byte |
| cmd_end | input | 1 | Close the current command |
| power_loss | input | 1 | Buffer contents became untrustworthy |
| copied | input | 1 | Buffer was copied to the array |
| rd_addr | output | 16 | Array byte address for the current lane |
| rd_data | input | 8 | Array byte at `rd_addr` (combinational) |
| prot_page | output | 2 | Data page whose protection code is needed |
| prot_data | input | 8 | Protection code of `prot_page` (combinational) |
| sp_data | output | 64 | Buffer contents, lane 0 in bits 7:0 |
| target_addr | output | 16 | Latched target address |
| es | output | 8 | Status: bit 7 copied, bit 5 partial, bits 2:0 end lane |
| copy_valid | output | 1 | Buffer is complete for a copy |
| target_invalid | output | 1 | Target lies beyond the array |

## Verification
Two pairs of functions can act on the same status bit in one cycle. The first pair is the byte that lands in lane 7, which clears the partial flag, and a `power_loss` pulse, which sets it. The second pair is an accepted byte, which clears the copied flag, and a `copied` pulse, which sets it. The bench drives each pair in one cycle: the eighth byte of a full row arrives together with `power_loss`, and a wrapping ninth byte arrives together with `copied`. It then expects the partial flag set and the copied flag clear. Ignored traffic is judged by offering bytes before any address load and after `cmd_end`, then comparing every buffer lane and the status byte with the unchanged model.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [1:0] {
    PM_OPEN = 2'd0,
    PM_LOCK = 2'd1,
    PM_BURN = 2'd2
  } prot_mode_e;

  localparam logic [7:0] LOCK_CODE = 8'h55;
  localparam logic [7:0] BURN_CODE = 8'hAA;

  function automatic prot_mode_e decode_prot(input logic [7:0] code);
    if (code == LOCK_CODE)      return PM_LOCK;
    else if (code == BURN_CODE) return PM_BURN;
    else                        return PM_OPEN;
  endfunction

endpackage

// File: rtl/spw_merge.sv
module spw_merge
  import spw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  prot_mode_e        mode,
  input  logic [BYTE_W-1:0] din,
  input  logic [BYTE_W-1:0] stored,
  output logic [BYTE_W-1:0] dout
);

  always_comb begin
    unique case (mode)
      PM_LOCK: dout = stored;
      PM_BURN: dout = din & stored;
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/spw_store.sv
module spw_store #(
  parameter int SP_BYTES = 8,
  parameter int BYTE_W   = 8,
  localparam int OFF_W   = $clog2(SP_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [OFF_W-1:0]             wr_lane,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [SP_BYTES*BYTE_W-1:0]   sp_data
);

  logic [SP_BYTES-1:0] lane_we;

  for (genvar i = 0; i < SP_BYTES; i++) begin : g_lane
    assign lane_we[i] = wr_en && (wr_lane == OFF_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sp_data[i*BYTE_W +: BYTE_W] <= '0;
      else if (lane_we[i]) sp_data[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we)) else $error("more than one lane written"); // R3

endmodule

// File: rtl/spw_status.sv
module spw_status #(
  parameter int SP_BYTES = 8,
  localparam int OFF_W   = $clog2(SP_BYTES),
  localparam int CNT_W   = $clog2(SP_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic             accept,
  input  logic             power_loss,
  input  logic             copied,
  output logic [OFF_W-1:0] ptr,
  output logic [OFF_W-1:0] end_off,
  output logic             partial,
  output logic             done_flag,
  output logic             full_row
);

  localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(SP_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(SP_BYTES);
  localparam logic [CNT_W-1:0] CNT_OVER  = CNT_W'(SP_BYTES + 1);

  logic             first_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      end_off   <= '0;
      partial   <= 1'b1;
      done_flag <= 1'b0;
      first_q   <= 1'b0;
      cnt_q     <= '0;
      start_q   <= '0;
    end else begin
      if (load) begin
        ptr       <= load_off;
        end_off   <= load_off;
        start_q   <= load_off;
        first_q   <= 1'b1;
        cnt_q     <= '0;
        done_flag <= 1'b0;
        partial   <= 1'b1;
      end else if (accept) begin
        ptr       <= ptr + OFF_W'(1);
        first_q   <= 1'b0;
        done_flag <= 1'b0;
        if (!first_q)          end_off <= end_off + OFF_W'(1);
        if (cnt_q != CNT_OVER) cnt_q   <= cnt_q + CNT_W'(1);
        if (ptr == LAST_LANE)  partial <= 1'b0;
      end else if (copied) begin
        done_flag <= 1'b1;
      end
      if (power_loss) partial <= 1'b1;
    end
  end

  assign full_row = (cnt_q == CNT_FULL) && (start_q == '0) && !partial;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ptr == $past(ptr) + OFF_W'(1)) else $error("pointer step"); // R3
  AST_LOAD_END: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> end_off == $past(load_off)) else $error("end lane load"); // R2
  AST_PF_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    power_loss |=> partial) else $error("partial after loss"); // R7
  AST_AA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_flag) else $error("copied flag after write"); // R8

endmodule

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int SP_BYTES   = 8,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int ARRAY_END  = 144,
  localparam int OFF_W     = $clog2(SP_BYTES),
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int PG_SHIFT  = $clog2(PAGE_BYTES),
  localparam int DATA_END  = PAGES * PAGE_BYTES,
  localparam int ES_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       addr_load,
  input  logic [ADDR_W-1:0]          addr_in,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [BYTE_W-1:0]          in_data,
  input  logic                       cmd_end,
  input  logic                       power_loss,
  input  logic                       copied,
  output logic [ADDR_W-1:0]          rd_addr,
  input  logic [BYTE_W-1:0]          rd_data,
  output logic [PAGE_W-1:0]          prot_page,
  input  logic [BYTE_W-1:0]          prot_data,
  output logic [SP_BYTES*BYTE_W-1:0] sp_data,
  output logic [ADDR_W-1:0]          target_addr,
  output logic [ES_W-1:0]            es,
  output logic                       copy_valid,
  output logic                       target_invalid
);

  logic              active_q;
  logic              accept;
  logic [OFF_W-1:0]  ptr;
  logic [OFF_W-1:0]  end_off;
  logic              partial;
  logic              done_flag;
  logic              in_data_page;
  prot_mode_e        mode;
  logic [BYTE_W-1:0] merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      target_addr <= '0;
    end else if (addr_load) begin
      active_q    <= 1'b1;
      target_addr <= addr_in;
    end else if (cmd_end) begin
      active_q    <= 1'b0;
    end
  end

  assign in_ready = active_q && !addr_load && !cmd_end;
  assign accept   = in_valid && in_ready;

  assign rd_addr      = {target_addr[ADDR_W-1:OFF_W], ptr};
  assign prot_page    = target_addr[PG_SHIFT +: PAGE_W];
  assign in_data_page = target_addr < ADDR_W'(DATA_END);
  assign mode         = in_data_page ? decode_prot(prot_data) : PM_OPEN;
  assign target_invalid = target_addr >= ADDR_W'(ARRAY_END);

  spw_merge #(.BYTE_W(BYTE_W)) u_merge (
    .mode   (mode),
    .din    (in_data),
    .stored (rd_data),
    .dout   (merged)
  );

  spw_store #(.SP_BYTES(SP_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_lane (ptr),
    .wr_data (merged),
    .sp_data (sp_data)
  );

  spw_status #(.SP_BYTES(SP_BYTES)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (addr_load),
    .load_off   (addr_in[OFF_W-1:0]),
    .accept     (accept),
    .power_loss (power_loss),
    .copied     (copied),
    .ptr        (ptr),
    .end_off    (end_off),
    .partial    (partial),
    .done_flag  (done_flag),
    .full_row   (copy_valid)
  );

  always_comb begin
    es            = '0;
    es[OFF_W-1:0] = end_off;
    es[5]         = partial;
    es[7]         = done_flag;
  end

  logic [OFF_W-1:0]  prev_lane;
  logic [BYTE_W-1:0] prev_byte;
  assign prev_lane = ptr - OFF_W'(1);
  assign prev_byte = sp_data[BYTE_W*int'(prev_lane) +: BYTE_W];

  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == PM_OPEN) |=> prev_byte == $past(in_data)) else $error("open store"); // R3
  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == PM_LOCK) |=> prev_byte == $past(rd_data)) else $error("lock store"); // R4
  AST_BURN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == PM_BURN) |=> (prev_byte & ~$past(rd_data)) == '0) else $error("burn rise"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> $stable(sp_data)) else $error("idle write"); // R10

endmodule

// File: tb/spw_ctrl_bench.sv
module spw_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ARR = 144;

  typedef struct packed {
    logic [63:0] sp;
    logic [7:0]  es;
    logic [15:0] ta;
    logic        cv;
    logic        inv;
    logic        rdy;
  } obs_t;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, in_valid = 0, cmd_end = 0, power_loss = 0, copied = 0;
  logic [15:0] addr_in = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, copy_valid, target_invalid;
  logic [15:0] rd_addr, target_addr;
  logic [7:0]  rd_data, prot_data, es;
  logic [1:0]  prot_page;
  logic [63:0] sp_data;

  logic [7:0] mem [0:ARR-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data   = (rd_addr < 16'(ARR)) ? mem[rd_addr] : 8'hFF;
  assign prot_data = mem[128 + int'(prot_page)];

  spw_ctrl u_spw_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_end(cmd_end), .power_loss(power_loss), .copied(copied),
    .rd_addr(rd_addr), .rd_data(rd_data), .prot_page(prot_page),
    .prot_data(prot_data), .sp_data(sp_data), .target_addr(target_addr),
    .es(es), .copy_valid(copy_valid), .target_invalid(target_invalid)
  );

  obs_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_sp [8];
  logic [15:0] m_ta;
  logic [2:0]  m_e, m_ptr, m_start;
  logic        m_pf, m_aa, m_first, m_act;
  int          m_cnt;

  function automatic obs_t model_obs();
    obs_t o;
    for (int i = 0; i < 8; i++) o.sp[i*8 +: 8] = m_sp[i];
    o.es  = {m_aa, 1'b0, m_pf, 2'b00, m_e};
    o.ta  = m_ta;
    o.cv  = (m_cnt == 8) && (m_start == 0) && !m_pf;
    o.inv = m_ta >= 16'h0090;
    o.rdy = m_act;
    return o;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] code;
    if (a >= 16'h0080) return d;
    code = mem[128 + int'(a[6:5])];
    if (code == 8'h55) return mem[a];
    if (code == 8'hAA) return d & mem[a];
    return d;
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_obs());
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  task automatic load(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr_load = 1; addr_in = a;
    @(posedge clk); #1;
    addr_load = 0;
    m_ta = a; m_e = a[2:0]; m_ptr = a[2:0]; m_start = a[2:0];
    m_pf = 1; m_aa = 0; m_first = 1; m_cnt = 0; m_act = 1;
    push(tag);
  endtask

  task automatic endc(input string tag);
    @(negedge clk);
    cmd_end = 1;
    @(posedge clk); #1;
    cmd_end = 0;
    m_act = 0;
    push(tag);
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic pl,
                     input logic cp, input string tag);
    @(negedge clk);
    in_valid = v; in_data = d; power_loss = pl; copied = cp;
    @(posedge clk); #1;
    in_valid = 0; power_loss = 0; copied = 0;
    if (v && m_act) begin
      m_sp[m_ptr] = exp_byte({m_ta[15:3], m_ptr}, d);
      if (!m_first) m_e = m_e + 3'd1;
      m_first = 0;
      if (m_ptr == 3'd7) m_pf = 0;
      m_ptr = m_ptr + 3'd1;
      if (m_cnt < 9) m_cnt++;
      m_aa = 0;
    end else if (cp) begin
      m_aa = 1;
    end
    if (pl) m_pf = 1;
    push(tag);
  endtask

  initial begin : monitor
    obs_t  e, a;
    string t;
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.sp = sp_data; a.es = es; a.ta = target_addr;
      a.cv = copy_valid; a.inv = target_invalid; a.rdy = in_ready;
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual sp=%h es=%h ta=%h cv=%b inv=%b rdy=%b expected sp=%h es=%h ta=%h cv=%b inv=%b rdy=%b",
                 t, a.sp, a.es, a.ta, a.cv, a.inv, a.rdy,
                 e.sp, e.es, e.ta, e.cv, e.inv, e.rdy);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < ARR; i++) mem[i] = 8'(i * 37 + 11);
    mem[128] = 8'h00; mem[129] = 8'h55; mem[130] = 8'hAA; mem[131] = 8'h12;
    for (int i = 0; i < 8; i++) m_sp[i] = 8'h00;
    m_ta = 0; m_e = 0; m_ptr = 0; m_start = 0; m_pf = 1; m_aa = 0;
    m_first = 0; m_act = 0; m_cnt = 0;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 push("R1 reset state");
    cyc(1, 8'h5A, 0, 0, "R10 byte before any load");

    load(16'h0000, "R2 load page0");
    for (int i = 0; i < 8; i++)
      cyc(1, 8'(8'h11 * (i + 1)), 0, 0, (i == 7) ? "R9 full row valid" : "R3 R6 open fill");
    cyc(0, 8'h00, 0, 1, "R8 copied sets flag");
    cyc(1, 8'h9C, 0, 1, "R8 R9 write beats copied, ninth byte");
    endc("R10 command end");
    cyc(1, 8'h77, 0, 0, "R10 byte after end ignored");

    load(16'h0025, "R2 load page1 lane5");
    for (int i = 0; i < 3; i++) cyc(1, 8'hC3, 0, 0, "R4 locked page");
    cyc(1, 8'h3C, 0, 0, "R3 R6 wrap to lane0");

    load(16'h0040, "R2 load page2");
    for (int i = 0; i < 8; i++) cyc(1, 8'(8'hF0 ^ (i * 8'h13)), 0, 0, "R5 burn page");

    load(16'h0048, "R2 load page2 row1");
    for (int i = 0; i < 4; i++) cyc(1, 8'hFF, 0, 0, "R7 short write keeps partial");
    endc("R7 partial after early end");

    load(16'h0060, "R2 load page3");
    for (int i = 0; i < 7; i++) cyc(1, 8'(8'hA0 + i), 0, 0, "R3 open page3");
    cyc(1, 8'hE7, 1, 0, "R7 loss beats lane7 clear");

    load(16'h0084, "R2 load register row");
    for (int i = 0; i < 4; i++) cyc(1, 8'(8'h55 + i), 0, 0, "R3 register row open");

    load(16'h0090, "R9 beyond array flagged");
    cyc(1, 8'hAA, 0, 0, "R3 beyond array open");
    cyc(0, 8'h00, 1, 0, "R7 power loss sets partial");
    endc("R10 final end");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule